// File: doc/BRIEF.md
# Binary Morphological Cleanup Filter

This block cleans up a binary raster stream after a brightness threshold has run. Each pixel is one bit: 1 is foreground (trail) and 0 is background. The block runs four 3×3 neighbourhood passes one after another. A closing (grow, then shrink) fills small holes inside the foreground. An opening (shrink, then grow) then deletes small foreground specks that lie outside it. It is a cheap substitute for finding the largest connected region.

Pixels arrive in raster order on a ready/valid stream. A start-of-frame flag marks the first pixel of a frame and an end-of-line flag marks the last pixel of a line. The length of the first line of each frame sets the line length, up to a compile-time maximum that sizes the line buffers. The frame height is a runtime input. Every pass is the same parameterised stage. Each stage holds two line buffers and a two-column window, and is driven by a four-state machine:
- ST_IDLE waits for a start-of-frame pixel. When one is accepted it moves to ST_FILL.
- ST_FILL only consumes the first row. At the end of that row it moves to ST_RUN, or straight to ST_DRAIN when the frame has one row.
- ST_RUN consumes a row and emits the row above it. At the end of the last input row it moves to ST_DRAIN.
- ST_DRAIN emits the final row with no input. At the end of that row it returns to ST_IDLE.

Every row has one extra padding step, which supplies the missing right-hand column.

Top module: `morph_cleanup`

## Requirements
- R1: The output frame equals the input frame after, in this order, a 3×3 dilation (OR of the nine neighbours), a 3×3 erosion (AND of the nine), another 3×3 erosion and another 3×3 dilation.
- R2: In a dilation pass, neighbours outside the frame count as 0. An all-zero frame leaves as all zeros, at any size.
- R3: In an erosion pass, neighbours outside the frame count as 1. An all-one frame leaves as all ones, at any size.
- R4: A single background pixel enclosed by foreground is filled. A 5×5 all-one frame with a 0 at its centre leaves as all ones.
- R5: A lone foreground pixel is removed. A 6×6 frame with a single 1 leaves as all zeros.
- R6: Each output frame holds exactly width×height pixels in raster order. out_sof is 1 only on pixel (0,0) and out_eol is 1 exactly on column width−1 of every row.
- R7: The line length is taken from the position of the first in_eol in the frame's first line. in_eol on later lines has no effect. cfg_height is sampled when the start-of-frame pixel is accepted. Both lie in 1..maximum.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_pix, out_sof and out_eol hold their values. No pixel is lost or duplicated under any pattern of out_ready.
- R9: After reset, out_valid is 0 and in_ready is 1.
- R10: While the block waits for a frame, it accepts and discards input pixels that carry no in_sof. They do not appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_height | input | $clog2(MAXH+1) | Frame height in rows, sampled at frame start |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel taken this cycle |
| in_pix | input | 1 | Input pixel, 1 = foreground |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_pix | output | 1 | Filtered pixel |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a line |

## Verification
The assertions assume the following about the inputs:
- cfg_height stays constant while a frame is inside the block.
- The first line of each frame ends with an in_eol no later than the maximum width.
- Every frame is complete before the next start-of-frame arrives.

Under these assumptions, the line-length assertion can compare every output line against the length of the first output line. The stimulus changes cfg_height only after the previous frame has fully left the block. It places in_eol exactly on the last column of each line. The one exception is a deliberate extra in_eol on a later line, which the design must ignore, so the output line lengths stay unchanged.

// File: rtl/morph_pkg.sv
package morph_pkg;

    typedef enum logic {
        OP_DILATE = 1'b0,
        OP_ERODE  = 1'b1
    } morph_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } stage_state_e;

    // Stage sequence: closing (dilate, erode) then opening (erode, dilate)
    function automatic morph_op_e stage_op(input int idx);
        return (idx == 1 || idx == 2) ? OP_ERODE : OP_DILATE;
    endfunction

    function automatic logic reduce9(input morph_op_e op, input logic [8:0] win);
        return (op == OP_ERODE) ? (&win) : (|win);
    endfunction

endpackage

// File: rtl/morph_linebuf.sv
module morph_linebuf #(
    parameter int MAXW = 1280
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [$clog2(MAXW+1)-1:0]   col,
    input  logic                        wr_bit,
    output logic                        rd_prev1,
    output logic                        rd_prev2
);
    // Two rows of history; index range covers the padding column too
    logic [MAXW:0] row_a;
    logic [MAXW:0] row_b;

    assign rd_prev1 = row_a[col];
    assign rd_prev2 = row_b[col];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            row_a[col] <= wr_bit;
            row_b[col] <= row_a[col];
        end
    end
endmodule

// File: rtl/morph_kernel.sv
module morph_kernel
    import morph_pkg::*;
#(
    parameter morph_op_e OP = OP_DILATE
) (
    input  logic [2:0] win_l,
    input  logic [2:0] win_m,
    input  logic       raw_bot,
    input  logic       raw_mid,
    input  logic       raw_top,
    input  logic       has_bot,
    input  logic       has_mid,
    input  logic       has_top,
    output logic [2:0] new_col,
    output logic       result
);
    localparam logic PAD = (OP == OP_ERODE);

    always_comb begin
        new_col[0] = has_bot ? raw_bot : PAD;
        new_col[1] = has_mid ? raw_mid : PAD;
        new_col[2] = has_top ? raw_top : PAD;
        result     = reduce9(OP, {win_l, win_m, new_col});
    end
endmodule

// File: rtl/morph_stage.sv
module morph_stage
    import morph_pkg::*;
#(
    parameter int        MAXW = 1280,
    parameter int        MAXH = 720,
    parameter morph_op_e OP   = OP_DILATE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAXH+1)-1:0]   cfg_height,
    input  logic                        i_valid,
    output logic                        i_ready,
    input  logic                        i_pix,
    input  logic                        i_sof,
    input  logic                        i_eol,
    output logic                        o_valid,
    input  logic                        o_ready,
    output logic                        o_pix,
    output logic                        o_sof,
    output logic                        o_eol
);
    localparam int             WW    = $clog2(MAXW+1);
    localparam int             HW    = $clog2(MAXH+1);
    localparam logic [WW-1:0]  W_MAX = WW'(MAXW);
    localparam logic [WW-1:0]  W_ONE = WW'(1);
    localparam logic [HW-1:0]  H_ONE = HW'(1);
    localparam logic [2:0]     PAD3  = (OP == OP_ERODE) ? 3'b111 : 3'b000;

    stage_state_e state_q, state_d;

    logic [WW-1:0] wid_q, vc_q, cur_w, cur_vc;
    logic [HW-1:0] hgt_q, vr_q, cur_h, cur_vr;
    logic [2:0]    win_l_q, win_m_q, new_col;
    logic          idle, in_col, row_end, needs_in, gives_out, slot_free, step;
    logic          lb_prev1, lb_prev2, result;

    // ---------------- position decode ----------------
    always_comb begin
        idle      = (state_q == ST_IDLE);
        cur_w     = idle ? W_MAX : wid_q;
        cur_h     = idle ? cfg_height : hgt_q;
        cur_vr    = idle ? '0 : vr_q;
        cur_vc    = idle ? '0 : vc_q;
        in_col    = (cur_vc < cur_w);
        row_end   = !idle && (cur_vc == cur_w);
        needs_in  = idle || ((state_q == ST_FILL || state_q == ST_RUN) && in_col);
        gives_out = (state_q == ST_RUN || state_q == ST_DRAIN) && (cur_vc != '0);
        slot_free = !o_valid || o_ready;
    end

    // ---------------- handshake ----------------
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                i_ready = 1'b1;
                step    = i_valid && i_sof;
            end
            default: begin
                i_ready = needs_in && (!gives_out || slot_free);
                step    = (!needs_in || i_valid) && (!gives_out || slot_free);
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (step) state_d = ST_FILL;
            ST_FILL,
            ST_RUN:   if (step && row_end)
                          state_d = ((cur_vr + H_ONE) == cur_h) ? ST_DRAIN : ST_RUN;
            ST_DRAIN: if (step && row_end) state_d = ST_IDLE;
        endcase
    end

    // ---------------- raster counters and geometry ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wid_q <= W_MAX;
            hgt_q <= H_ONE;
            vr_q  <= '0;
            vc_q  <= '0;
        end else if (step) begin
            if (idle) begin
                hgt_q <= cfg_height;
                wid_q <= i_eol ? W_ONE : W_MAX;
                vr_q  <= '0;
                vc_q  <= W_ONE;
            end else begin
                if (state_q == ST_FILL && in_col && i_eol)
                    wid_q <= cur_vc + W_ONE;
                if (row_end) begin
                    vc_q <= '0;
                    vr_q <= vr_q + H_ONE;
                end else begin
                    vc_q <= vc_q + W_ONE;
                end
            end
        end
    end

    // ---------------- window columns ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_l_q <= PAD3;
            win_m_q <= PAD3;
        end else if (step) begin
            if (cur_vc == '0) begin
                win_l_q <= PAD3;
                win_m_q <= new_col;
            end else begin
                win_l_q <= win_m_q;
                win_m_q <= new_col;
            end
        end
    end

    morph_linebuf #(.MAXW(MAXW)) u_lbuf (
        .clk      (clk),
        .wr_en    (step && in_col),
        .col      (cur_vc),
        .wr_bit   (new_col[0]),
        .rd_prev1 (lb_prev1),
        .rd_prev2 (lb_prev2)
    );

    morph_kernel #(.OP(OP)) u_kern (
        .win_l   (win_l_q),
        .win_m   (win_m_q),
        .raw_bot (i_pix),
        .raw_mid (lb_prev1),
        .raw_top (lb_prev2),
        .has_bot (needs_in),
        .has_mid (in_col && (cur_vr != '0)),
        .has_top (in_col && (cur_vr > H_ONE)),
        .new_col (new_col),
        .result  (result)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_pix   <= 1'b0;
            o_sof   <= 1'b0;
            o_eol   <= 1'b0;
        end else if (step && gives_out) begin
            o_valid <= 1'b1;
            o_pix   <= result;
            o_sof   <= (cur_vr == H_ONE) && (cur_vc == W_ONE);
            o_eol   <= row_end;
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/morph_cleanup.sv
module morph_cleanup
    import morph_pkg::*;
#(
    parameter int MAXW = 1280,
    parameter int MAXH = 720
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAXH+1)-1:0]   cfg_height,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_pix,
    input  logic                        in_sof,
    input  logic                        in_eol,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic                        out_pix,
    output logic                        out_sof,
    output logic                        out_eol
);
    localparam int NSTAGE = 4;

    logic [NSTAGE:0] lk_valid, lk_ready, lk_pix, lk_sof, lk_eol;

    assign lk_valid[0] = in_valid;
    assign lk_pix[0]   = in_pix;
    assign lk_sof[0]   = in_sof;
    assign lk_eol[0]   = in_eol;
    assign in_ready    = lk_ready[0];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        morph_stage #(
            .MAXW (MAXW),
            .MAXH (MAXH),
            .OP   (stage_op(g))
        ) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_height (cfg_height),
            .i_valid    (lk_valid[g]),
            .i_ready    (lk_ready[g]),
            .i_pix      (lk_pix[g]),
            .i_sof      (lk_sof[g]),
            .i_eol      (lk_eol[g]),
            .o_valid    (lk_valid[g+1]),
            .o_ready    (lk_ready[g+1]),
            .o_pix      (lk_pix[g+1]),
            .o_sof      (lk_sof[g+1]),
            .o_eol      (lk_eol[g+1])
        );
    end

    assign lk_ready[NSTAGE] = out_ready;
    assign out_valid        = lk_valid[NSTAGE];
    assign out_pix          = lk_pix[NSTAGE];
    assign out_sof          = lk_sof[NSTAGE];
    assign out_eol          = lk_eol[NSTAGE];
endmodule

// File: rtl/morph_cleanup_chk.sv
module morph_cleanup_chk #(
    parameter int MAXW = 1280
) (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic out_ready,
    input logic out_pix,
    input logic out_sof,
    input logic out_eol
);
    localparam int WW = $clog2(MAXW+1);

    logic          acc, have_w, have_eff;
    logic [WW-1:0] col_cnt, col_now, w_rec;
    logic          line_start;

    assign acc      = out_valid && out_ready;
    assign col_now  = out_sof ? '0 : col_cnt;
    assign have_eff = out_sof ? 1'b0 : have_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_cnt    <= '0;
            w_rec      <= '0;
            have_w     <= 1'b0;
            line_start <= 1'b1;
        end else if (acc) begin
            line_start <= out_eol;
            if (out_eol) begin
                col_cnt <= '0;
                have_w  <= 1'b1;
                if (!have_eff) w_rec <= col_now + WW'(1);
            end else begin
                col_cnt <= col_now + WW'(1);
                have_w  <= have_eff;
            end
        end
    end

    // R8: a stalled output holds its pixel and flags
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)));

    // R6: a frame starts only where a line starts
    assert_sof_line_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> line_start);

    // R6: later lines end at the same column as the first line of the frame
    assert_eol_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && out_eol && !out_sof && have_w) |-> (col_cnt == w_rec - WW'(1)));

    // R6: no line runs longer than the first line
    assert_line_not_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !out_eol && !out_sof && have_w) |-> (col_cnt < w_rec - WW'(1)));

    // R9: reset clears the output stream
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind morph_cleanup morph_cleanup_chk #(.MAXW(MAXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
);

// File: tb/morph_cleanup_bench.sv
`timescale 1ns/1ps
module morph_cleanup_bench;
    localparam int MW = 12;
    localparam int MH = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_height = 4'd1;
    logic       in_valid = 1'b0, in_pix = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, out_pix, out_sof, out_eol;

    int total = 0;
    int bad = 0;
    int hold_bad = 0;

    bit img   [0:MH-1][0:MW-1];
    bit work  [0:MH-1][0:MW-1];
    bit nxt   [0:MH-1][0:MW-1];
    bit expct [0:MH-1][0:MW-1];

    morph_cleanup #(.MAXW(MW), .MAXH(MH)) u_morph_cleanup (
        .clk(clk), .rst_n(rst_n), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
        $finish;
    end

    // One 3x3 pass by definition: out-of-frame neighbour = 1 for erosion, 0 for dilation
    task automatic ref_pass(input int w, input int h, input bit erode);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                bit a = erode;
                for (int dr = -1; dr <= 1; dr++) begin
                    for (int dc = -1; dc <= 1; dc++) begin
                        int rr = r + dr;
                        int cc = c + dc;
                        bit v = (rr >= 0 && rr < h && cc >= 0 && cc < w) ? work[rr][cc] : erode;
                        a = erode ? (a & v) : (a | v);
                    end
                end
                nxt[r][c] = a;
            end
        end
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                work[r][c] = nxt[r][c];
    endtask

    task automatic build_expected(input int w, input int h);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                work[r][c] = img[r][c];
        ref_pass(w, h, 1'b0);
        ref_pass(w, h, 1'b1);
        ref_pass(w, h, 1'b1);
        ref_pass(w, h, 1'b0);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                expct[r][c] = work[r][c];
    endtask

    task automatic fill_const(input int w, input int h, input bit v);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                img[r][c] = v;
    endtask

    task automatic send_px(input bit p, input bit s, input bit e);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p; in_sof = s; in_eol = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic run_frame(input int w, input int h, input string tag,
                             input int junk, input bit spur, input int rdy_pct);
        int errs = 0;
        int extra = 0;
        int mr = 0, mc = 0;
        logic [2:0] m_act = '0, m_exp = '0;
        cfg_height = h[3:0];
        fork
            begin
                for (int j = 0; j < junk; j++) send_px(1'b1, 1'b0, 1'b0);
                for (int r = 0; r < h; r++)
                    for (int c = 0; c < w; c++)
                        send_px(img[r][c], (r == 0 && c == 0),
                                (c == w - 1) || (spur && r == 1 && c == 0));
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            end
            begin
                int got = 0;
                bit pv = 0, pr = 0, pp = 0, ps = 0, pe = 0;
                while (got < w * h) begin
                    @(negedge clk);
                    out_ready = ($urandom_range(99) < rdy_pct);
                    #1;
                    if (pv && !pr && !(out_valid && out_pix == pp && out_sof == ps && out_eol == pe))
                        hold_bad++;
                    pv = out_valid; pr = out_ready; pp = out_pix; ps = out_sof; pe = out_eol;
                    if (out_valid && out_ready) begin
                        int r = got / w;
                        int c = got % w;
                        logic [2:0] ex = {expct[r][c], (got == 0), (c == w - 1)};
                        logic [2:0] ac = {out_pix, out_sof, out_eol};
                        if (ac !== ex) begin
                            if (errs == 0) begin mr = r; mc = c; m_act = ac; m_exp = ex; end
                            errs++;
                        end
                        got++;
                    end
                end
            end
        join
        out_ready = 1'b1;
        repeat (10) begin
            @(negedge clk);
            #1;
            if (out_valid) extra++;
        end
        total++;
        if (errs != 0 || extra != 0) begin
            bad++;
            $display("FAIL %s %0dx%0d: %0d bad pixels, first (%0d,%0d) actual pix/sof/eol=%b expected=%b, extra=%0d expected extra=0",
                     tag, w, h, errs, mr, mc, m_act, m_exp, extra);
        end
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R9: reset state
        total++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            bad++;
            $display("FAIL R9 reset: actual out_valid=%b in_ready=%b expected out_valid=0 in_ready=1",
                     out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all-zero frames of several sizes stay zero
        fill_const(MW, MH, 1'b0);
        fill_const(MW, MH, 1'b0);
        for (int r = 0; r < MH; r++) for (int c = 0; c < MW; c++) expct[r][c] = 1'b0;
        run_frame(7, 5, "R2 zero frame", 0, 0, 100);
        run_frame(1, 1, "R2 zero 1x1", 0, 0, 60);

        // R3: all-one frames stay one
        fill_const(MW, MH, 1'b1);
        for (int r = 0; r < MH; r++) for (int c = 0; c < MW; c++) expct[r][c] = 1'b1;
        run_frame(6, 4, "R3 one frame", 0, 0, 100);
        run_frame(MW, MH, "R3 one full size", 0, 0, 70);
        run_frame(1, 3, "R3 one 1x3", 0, 0, 50);

        // R4: enclosed hole filled
        fill_const(5, 5, 1'b1);
        img[2][2] = 1'b0;
        for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) expct[r][c] = 1'b1;
        run_frame(5, 5, "R4 hole", 0, 0, 80);

        // R5: lone speck removed
        fill_const(6, 6, 1'b0);
        img[2][3] = 1'b1;
        for (int r = 0; r < 6; r++) for (int c = 0; c < 6; c++) expct[r][c] = 1'b0;
        run_frame(6, 6, "R5 speck", 0, 0, 80);

        // R10: leading pixels without start-of-frame are dropped
        for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) img[r][c] = ((r * 4 + c) % 3) != 0;
        build_expected(4, 4);
        run_frame(4, 4, "R10 junk before frame", 3, 0, 80);

        // R7: stray line marker on a later line does not change geometry
        for (int r = 0; r < 4; r++) for (int c = 0; c < 5; c++) img[r][c] = $urandom_range(1);
        build_expected(5, 4);
        run_frame(5, 4, "R7 stray eol", 0, 1, 80);

        // R1 R6: every 3x3 image, with backpressure
        for (int k = 0; k < 512; k++) begin
            for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) img[r][c] = k[r * 3 + c];
            build_expected(3, 3);
            run_frame(3, 3, "R1 R6 exhaustive 3x3", 0, 0, 75);
        end

        // R1 R6 R7 R8: size sweep with random content and backpressure
        for (int w = 1; w <= MW; w++) begin
            for (int h = 1; h <= MH; h++) begin
                for (int r = 0; r < h; r++)
                    for (int c = 0; c < w; c++)
                        img[r][c] = ($urandom_range(99) < 60);
                build_expected(w, h);
                run_frame(w, h, "R1 R6 R7 size sweep", 0, 0, 65);
            end
        end

        // R8: stalled outputs held
        total++;
        if (hold_bad != 0) begin
            bad++;
            $display("FAIL R8 hold: actual changes while stalled=%0d expected=0", hold_bad);
        end

        summary();
        $finish;
    end
endmodule